// File: doc/BRIEF.md
# Dual-Rail Completion-Detecting Ripple Adder

This block adds two WIDTH-bit operands and a carry-in. Every carry along its chain is held as a two-wire code, so "not yet known" is a state of its own. The adder therefore reports the moment the result is final, instead of waiting out a fixed worst-case delay. A one-cycle start strobe captures the operands and empties every carry pair. Each later cycle of the local step clock lets resolved carries move one position further up the chain. When every pair holds a valid code, `done_o` rises. The sum and carry-out are then final, and `steps_o` reports how many step cycles the addition took.

The latency depends on the data. A position whose two operand bits match settles its carry on the first step, whatever carry arrives from below. A position whose bits differ has to wait for its neighbour below. The total time is therefore set by the longest run of differing bit positions.

Top module: `dr_ripple_adder`

## Requirements
- R1: Each carry pair is written (false-rail, true-rail). 2'b00 means empty, 2'b01 means carry false, 2'b10 means carry true, and 2'b11 never occurs. `cout_o` is 1 exactly when the top carry pair holds 2'b10.
- R2: A cycle with `start_i` high loads `a_i`, `b_i` and `cin_i` and empties every carry pair. After that edge, `done_o` is 0 and `steps_o` is 0.
- R3: On the first step after start, the carry-in pair and the carry out of every position with equal operand bits resolve. The carry is true for 1/1 and false for 0/0.
- R4: A position with differing operand bits copies the resolved carry from the position below one step after that carry became valid.
- R5: `done_o` is high exactly when all WIDTH+1 carry pairs are valid. It then stays high, and `steps_o` stays constant, until the next start.
- R6: While `done_o` is high, {`cout_o`, `sum_o`} equals `a + b + cin`.
- R7: When `done_o` rises, `steps_o` equals the length of the longest run of adjacent positions with differing bits, plus one.
- R8: Adding 1 to all ones takes WIDTH steps. All ones plus zero takes WIDTH+1 steps, which is the maximum.
- R9: Adding 1 to 0 takes 2 steps. Operands with no differing bit (for example equal operands) take 1 step, which is the minimum.
- R10: Once a carry pair is valid, it keeps its code until the next start.
- R11: A start that arrives before `done_o` has risen abandons the addition in flight and begins the new one from empty carries.
- R12: After reset, `done_o`, `steps_o`, `sum_o` and `cout_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local step clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Loads the operands and empties the carry chain |
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| cin_i | input | 1 | Carry-in |
| sum_o | output | WIDTH | Sum, valid while done_o is high |
| cout_o | output | 1 | Carry-out, valid while done_o is high |
| done_o | output | 1 | All carry pairs hold valid codes |
| steps_o | output | $clog2(WIDTH+2) | Step cycles used by the current addition |

## Verification
The properties assume that `start_i` is a clean synchronous pulse. They also assume the operands only matter on start cycles: the adder captures them there and ignores them at all other times. The stimulus drives inputs on the falling edge and holds start for exactly one cycle. It waits for `done_o` before the next start, except in the deliberate restart case. Random operands come from a fixed seed and are mixed with all-ones, zero and equal-operand cases, so that both the longest and the shortest carry chains occur.

// File: rtl/dr_adder_pkg.sv
package dr_adder_pkg;
  typedef enum logic [1:0] {
    RAIL_EMPTY = 2'b00,
    RAIL_FALSE = 2'b01,
    RAIL_TRUE  = 2'b10
  } rail_t;
endpackage

// File: rtl/dr_carry_cell.sv
module dr_carry_cell
  import dr_adder_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clr_i,
  input  logic  step_i,
  input  logic  a_i,
  input  logic  b_i,
  input  rail_t below_i,
  output rail_t carry_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      carry_o <= RAIL_EMPTY;
    end else if (clr_i) begin
      carry_o <= RAIL_EMPTY;
    end else if (step_i && carry_o == RAIL_EMPTY) begin
      // generate/kill settles at once, propagate waits for the pair below
      if (a_i == b_i) carry_o <= a_i ? RAIL_TRUE : RAIL_FALSE;
      else if (below_i != RAIL_EMPTY) carry_o <= below_i;
    end
  end
endmodule

// File: rtl/dr_done_tree.sv
module dr_done_tree #(
  parameter int unsigned N = 17
) (
  input  logic [N-1:0] valid_i,
  output logic         all_o
);
  localparam int unsigned HALF = N / 2;

  generate
    if (N == 1) begin : g_leaf
      assign all_o = valid_i[0];
    end else begin : g_split
      logic lo_all, hi_all;
      dr_done_tree #(.N(HALF)) i_lo (
        .valid_i(valid_i[HALF-1:0]),
        .all_o  (lo_all)
      );
      dr_done_tree #(.N(N - HALF)) i_hi (
        .valid_i(valid_i[N-1:HALF]),
        .all_o  (hi_all)
      );
      assign all_o = lo_all & hi_all;
    end
  endgenerate
endmodule

// File: rtl/dr_step_counter.sv
module dr_step_counter #(
  parameter int unsigned CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  output logic [CW-1:0] count_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     count_o <= '0;
    else if (clr_i)  count_o <= '0;
    else if (en_i)   count_o <= count_o + 1'b1;
  end
endmodule

// File: rtl/dr_ripple_adder.sv
module dr_ripple_adder
  import dr_adder_pkg::*;
#(
  parameter int unsigned WIDTH = 16,
  localparam int unsigned CW = $clog2(WIDTH + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             done_o,
  output logic [CW-1:0]    steps_o
);
  localparam int unsigned NPAIR = WIDTH + 1;

  logic [WIDTH-1:0]     a_q, b_q;
  logic                 cin_q, busy_q;
  rail_t                chain [NPAIR];
  logic [NPAIR-1:0]     chain_valid;
  logic [2*NPAIR-1:0]   chain_flat;
  logic                 step_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q    <= '0;
      b_q    <= '0;
      cin_q  <= 1'b0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      a_q    <= a_i;
      b_q    <= b_i;
      cin_q  <= cin_i;
      busy_q <= 1'b1;
    end else if (done_o) begin
      busy_q <= 1'b0;
    end
  end

  assign step_en = busy_q;

  // carry-in enters as a position with equal bits, so it settles on step 1
  dr_carry_cell i_cin_cell (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_i),
    .step_i (step_en),
    .a_i    (cin_q),
    .b_i    (cin_q),
    .below_i(RAIL_EMPTY),
    .carry_o(chain[0])
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    dr_carry_cell i_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (start_i),
      .step_i (step_en),
      .a_i    (a_q[i]),
      .b_i    (b_q[i]),
      .below_i(chain[i]),
      .carry_o(chain[i+1])
    );
    assign sum_o[i] = a_q[i] ^ b_q[i] ^ (chain[i] == RAIL_TRUE);
  end

  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    assign chain_valid[k]      = (chain[k] != RAIL_EMPTY);
    assign chain_flat[2*k +: 2] = chain[k];
  end

  dr_done_tree #(.N(NPAIR)) i_done_tree (
    .valid_i(chain_valid),
    .all_o  (done_o)
  );

  dr_step_counter #(.CW(CW)) i_steps (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_i),
    .en_i   (busy_q && !done_o),
    .count_o(steps_o)
  );

  assign cout_o = (chain[WIDTH] == RAIL_TRUE);
endmodule

// File: rtl/dr_ripple_adder_chk.sv
module dr_ripple_adder_chk #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned CW = 5
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 start_i,
  input logic                 done_o,
  input logic [CW-1:0]        steps_o,
  input logic [WIDTH-1:0]     sum_o,
  input logic                 cout_o,
  input logic [WIDTH-1:0]     a_q,
  input logic [WIDTH-1:0]     b_q,
  input logic                 cin_q,
  input logic [2*WIDTH+1:0]   chain_flat
);
  p_start_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!done_o && steps_o == '0));

  p_done_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(steps_o)));

  p_sum_correct_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ({cout_o, sum_o} == ({1'b0, a_q} + {1'b0, b_q} + {{WIDTH{1'b0}}, cin_q})));

  p_steps_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    steps_o <= CW'(WIDTH + 1));

  for (genvar i = 0; i <= WIDTH; i++) begin : g_pair_chk
    p_no_illegal_code_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      chain_flat[2*i +: 2] != 2'b11);

    p_monotone_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (chain_flat[2*i +: 2] != 2'b00 && !start_i) |=>
        (chain_flat[2*i +: 2] == $past(chain_flat[2*i +: 2])));
  end
endmodule

bind dr_ripple_adder dr_ripple_adder_chk #(.WIDTH(WIDTH), .CW(CW)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .done_o    (done_o),
  .steps_o   (steps_o),
  .sum_o     (sum_o),
  .cout_o    (cout_o),
  .a_q       (a_q),
  .b_q       (b_q),
  .cin_q     (cin_q),
  .chain_flat(chain_flat)
);

// File: tb/test_dr_ripple_adder.sv
`timescale 1ns/1ps
module test_dr_ripple_adder;
  localparam int unsigned WIDTH = 16;
  localparam int unsigned CW = $clog2(WIDTH + 2);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [WIDTH-1:0] a = '0, b = '0;
  logic             cin = 1'b0;
  logic [WIDTH-1:0] sum;
  logic             cout, done;
  logic [CW-1:0]    steps;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dr_ripple_adder #(.WIDTH(WIDTH)) i_dr_ripple_adder (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .a_i(a), .b_i(b), .cin_i(cin),
    .sum_o(sum), .cout_o(cout), .done_o(done), .steps_o(steps)
  );

  function automatic int exp_steps(logic [WIDTH-1:0] x, logic [WIDTH-1:0] y);
    int run = 0, best = 0;
    for (int i = 0; i < WIDTH; i++) begin
      if (x[i] ^ y[i]) run++;
      else run = 0;
      if (run > best) best = run;
    end
    return best + 1;
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start(logic [WIDTH-1:0] x, logic [WIDTH-1:0] y, logic c);
    @(negedge clk);
    a = x; b = y; cin = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0; a = ~x; b = ~y; cin = ~c;  // ignored outside start
  endtask

  task automatic run_add(logic [WIDTH-1:0] x, logic [WIDTH-1:0] y, logic c, string tag);
    logic [WIDTH:0] ref_sum;
    int n = 0;
    int es;
    pulse_start(x, y, c);
    check({tag, " R2 done after start"}, done, 0);
    check({tag, " R2 steps after start"}, steps, 0);
    while (!done && n < WIDTH + 4) begin
      @(negedge clk);
      n++;
    end
    es = exp_steps(x, y);
    ref_sum = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, c};
    check({tag, " R5 done reached"}, done, 1);
    check({tag, " R7 cycles to done"}, n, es);
    check({tag, " R7 steps_o"}, steps, es);
    check({tag, " R6 sum"}, sum, ref_sum[WIDTH-1:0]);
    check({tag, " R1 cout"}, cout, ref_sum[WIDTH]);
    repeat (2) @(negedge clk);
    check({tag, " R5 done held"}, done, 1);
    check({tag, " R5 steps held"}, steps, es);
    check({tag, " R10 sum stable"}, sum, ref_sum[WIDTH-1:0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #1;
    check("R12 done at reset", done, 0);
    check("R12 steps at reset", steps, 0);
    check("R12 sum at reset", sum, 0);
    check("R12 cout at reset", cout, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 done idle", done, 0);

    run_add({WIDTH{1'b1}}, 1, 0, "R8 all-ones plus one");
    check("R8 worst ripple count", steps, WIDTH);
    run_add({WIDTH{1'b1}}, 0, 0, "R8 all-ones plus zero");
    check("R8 maximum count", steps, WIDTH + 1);
    run_add(0, 1, 0, "R9 zero plus one");
    check("R9 two steps", steps, 2);
    run_add(16'h5a3c, 16'h5a3c, 1, "R9 equal operands");
    check("R9 one step", steps, 1);
    run_add(0, 0, 1, "R3 carry-in only");
    run_add({WIDTH{1'b1}}, {WIDTH{1'b1}}, 1, "R3 all generate");
    run_add(16'h00ff, 16'h0f00, 1, "R4 mid propagate run");

    // R11: restart before completion
    pulse_start({WIDTH{1'b1}}, 1, 0);
    @(negedge clk);
    check("R11 not done mid-flight", done, 0);
    run_add(16'h1234, 16'h4321, 0, "R11 restart");

    for (int k = 0; k < 300; k++) begin
      run_add(WIDTH'($urandom), WIDTH'($urandom), 1'($urandom), "R7 random");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule